// File: doc/BRIEF.md
# Dual Independent 32-bit Timer

The block holds two separate 32-bit up-counters, the low half and the high half, behind a small word-addressed register bus. Each half has its own period register and its own 2-bit run mode, which is either stopped, single-shot or repeating. Both run modes live in one shared control word. A global configuration word selects the operating mode and releases each half from reset. When a running counter reaches its period, the counter returns to zero and that half's interrupt line pulses for one clock. In single-shot mode the hardware also sets that half's run mode back to stopped.

An optional compare register watches the low counter. It raises an event each time the counter steps onto the programmed value. A low half that repeats over the full 32-bit range can therefore be a free-running time base and an event source at once. The register bus is a plain control interface with no back-pressure. A write takes effect at the clock edge where `reg_wr` is high. `reg_rdata` follows `reg_addr` combinationally.

Top module: `dual_timer`

## Requirements
- R1: After reset every register reads zero, and `irq_lo`, `irq_hi` and `cmp_evt` are low.
- R2: The registers sit at these byte offsets: low counter 0x10, high counter 0x14, low period 0x18, high period 0x1C, run-mode control 0x20, global configuration 0x24, compare 0x28. Period, control, configuration and compare registers read back the last written word. An unmapped offset reads zero.
- R3: A half counts up by one per clock when three conditions hold: global bits 3:2 equal 1, the half's release bit is 1 (bit 0 for low, bit 1 for high), and the half's run-mode field is nonzero (control bits 7:6 for low, bits 23:22 for high).
- R4: A run-mode value of 2 (or 3) is repeating. In the clock after the counter equals its period, the counter becomes zero and the half's interrupt is high for exactly that one cycle. A period of N therefore gives one pulse every N+1 clocks.
- R5: A run-mode value of 1 is single-shot. At the match the counter goes to zero, the interrupt pulses, the half's run-mode field is cleared to 0 and the counter then stays at zero. The other half's field is left unchanged.
- R6: A half whose release bit is 0, whose run mode is 0, or whose global mode is not 1 keeps its counter value and raises no interrupt.
- R7: A software write to a counter loads that value at the next edge. The load overrides the count step and any match in that cycle.
- R8: The two halves count and match against their own periods independently.
- R9: `cmp_evt` pulses for one cycle in the cycle where the running low counter steps onto the compare value. This includes the step made by a wrap to zero. A counter that is not stepping raises no event.
- R10: With a period of all ones, the counter passes through 0xFFFFFFFF and wraps to zero with an interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | AW (8) | Byte offset of the register |
| reg_wdata | input | DW (32) | Write data |
| reg_rdata | output | DW (32) | Read data for `reg_addr` |
| irq_lo | output | 1 | Low half match pulse |
| irq_hi | output | 1 | High half match pulse |
| cmp_evt | output | 1 | Low counter compare event pulse |

## Verification
The counting function is tried with both halves repeating on unequal periods (4 and 6). This separates a shared match path from two independent ones and fixes the pulse spacing at N+1. A single-shot pattern alongside a repeating high half shows that the self-clear touches only its own field. Three held patterns check that each gating condition stops the count on its own: a half kept in reset, a stopped run mode, and a wrong global mode. A start near 0xFFFFFFFF with an all-ones period, followed by a counter load in mid-run, tells the full-range wrap apart from a narrower comparison and shows that a load wins over the step. A compare value hit on each pass of a short period shows the event repeats after every wrap and never fires while the counter is stopped.

// File: rtl/timer_pkg.sv
package timer_pkg;

  typedef enum logic [1:0] {
    RUN_STOP = 2'd0,
    RUN_ONCE = 2'd1,
    RUN_LOOP = 2'd2,
    RUN_ALT  = 2'd3
  } run_mode_e;

  localparam logic [7:0] OFS_CNT_LO = 8'h10;
  localparam logic [7:0] OFS_CNT_HI = 8'h14;
  localparam logic [7:0] OFS_PRD_LO = 8'h18;
  localparam logic [7:0] OFS_PRD_HI = 8'h1C;
  localparam logic [7:0] OFS_RUN    = 8'h20;
  localparam logic [7:0] OFS_CFG    = 8'h24;
  localparam logic [7:0] OFS_CMP    = 8'h28;

  localparam int unsigned RUN_LSB_LO = 6;
  localparam int unsigned RUN_LSB_HI = 22;
  localparam logic [1:0]  CFG_DUAL   = 2'd1;

  function automatic int unsigned run_lsb(int unsigned half);
    return (half == 0) ? RUN_LSB_LO : RUN_LSB_HI;
  endfunction

  function automatic logic [7:0] cnt_ofs(int unsigned half);
    return (half == 0) ? OFS_CNT_LO : OFS_CNT_HI;
  endfunction

endpackage

// File: rtl/timer_half.sv
module timer_half #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         once,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic [W-1:0] prd,
  output logic [W-1:0] cnt,
  output logic [W-1:0] nxt,
  output logic         step,
  output logic         done,
  output logic         hit
);

  logic match;

  assign step  = run && !ld;
  assign match = (cnt == prd);
  assign nxt   = match ? '0 : cnt + 1'b1;
  assign done  = step && once && match;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      hit <= 1'b0;
    end else begin
      if (ld)        cnt <= ld_val;
      else if (step) cnt <= nxt;
      hit <= step && match;
    end
  end

endmodule

// File: rtl/timer_cmp.sv
module timer_cmp #(
  parameter int unsigned W  = 32,
  parameter bit          EN = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wdata,
  input  logic         step,
  input  logic [W-1:0] nxt,
  output logic [W-1:0] cmp_q,
  output logic         evt
);

  generate
    if (EN) begin : g_cmp
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cmp_q <= '0;
          evt   <= 1'b0;
        end else begin
          if (we) cmp_q <= wdata;
          evt <= step && (nxt == cmp_q);
        end
      end
    end else begin : g_none
      assign cmp_q = '0;
      assign evt   = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/dual_timer.sv
module dual_timer
  import timer_pkg::*;
#(
  parameter int unsigned DW      = 32,
  parameter int unsigned AW      = 8,
  parameter bit          HAS_CMP = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          irq_lo,
  output logic          irq_hi,
  output logic          cmp_evt
);

  localparam int unsigned NHALF = 2;

  logic [DW-1:0] run_q, cfg_q;
  logic [DW-1:0] prd_q [NHALF];
  logic [DW-1:0] cnt   [NHALF];
  logic [DW-1:0] nxt   [NHALF];
  logic [NHALF-1:0] run, once, ld, step, done, hit;
  logic [DW-1:0] cmp_q;
  logic dual;

  assign dual = (cfg_q[3:2] == CFG_DUAL);

  generate
    for (genvar g = 0; g < NHALF; g++) begin : g_half
      logic [1:0] fld;
      assign fld     = run_q[run_lsb(g) +: 2];
      assign run[g]  = dual && cfg_q[g] && (fld != RUN_STOP);
      assign once[g] = (fld == RUN_ONCE);
      assign ld[g]   = reg_wr && (reg_addr == AW'(cnt_ofs(g)));

      timer_half #(.W(DW)) u_half (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run[g]),
        .once   (once[g]),
        .ld     (ld[g]),
        .ld_val (reg_wdata),
        .prd    (prd_q[g]),
        .cnt    (cnt[g]),
        .nxt    (nxt[g]),
        .step   (step[g]),
        .done   (done[g]),
        .hit    (hit[g])
      );
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q    <= '0;
      cfg_q    <= '0;
      prd_q[0] <= '0;
      prd_q[1] <= '0;
    end else begin
      if (reg_wr && reg_addr == AW'(OFS_RUN)) begin
        run_q <= reg_wdata;
      end else begin
        for (int h = 0; h < NHALF; h++)
          if (done[h]) run_q[run_lsb(h) +: 2] <= RUN_STOP;
      end
      if (reg_wr && reg_addr == AW'(OFS_CFG))    cfg_q    <= reg_wdata;
      if (reg_wr && reg_addr == AW'(OFS_PRD_LO)) prd_q[0] <= reg_wdata;
      if (reg_wr && reg_addr == AW'(OFS_PRD_HI)) prd_q[1] <= reg_wdata;
    end
  end

  timer_cmp #(.W(DW), .EN(HAS_CMP)) u_cmp (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (reg_wr && reg_addr == AW'(OFS_CMP)),
    .wdata (reg_wdata),
    .step  (step[0]),
    .nxt   (nxt[0]),
    .cmp_q (cmp_q),
    .evt   (cmp_evt)
  );

  always_comb begin
    case (reg_addr)
      AW'(OFS_CNT_LO): reg_rdata = cnt[0];
      AW'(OFS_CNT_HI): reg_rdata = cnt[1];
      AW'(OFS_PRD_LO): reg_rdata = prd_q[0];
      AW'(OFS_PRD_HI): reg_rdata = prd_q[1];
      AW'(OFS_RUN):    reg_rdata = run_q;
      AW'(OFS_CFG):    reg_rdata = cfg_q;
      AW'(OFS_CMP):    reg_rdata = cmp_q;
      default:         reg_rdata = '0;
    endcase
  end

  assign irq_lo = hit[0];
  assign irq_hi = hit[1];

endmodule

// File: rtl/dual_timer_chk.sv
module dual_timer_chk #(
  parameter int unsigned DW = 32,
  parameter int unsigned AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_wr,
  input logic [AW-1:0] reg_addr,
  input logic          irq_lo,
  input logic          irq_hi,
  input logic          cmp_evt,
  input logic [DW-1:0] run_q,
  input logic [DW-1:0] cnt_lo,
  input logic [DW-1:0] cmp_val,
  input logic          run_lo
);

  logic wr_run, ld_lo;
  assign wr_run = reg_wr && (reg_addr == AW'(8'h20));
  assign ld_lo  = reg_wr && (reg_addr == AW'(8'h10));

  p_wrap_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_lo |-> (cnt_lo == '0));

  p_step_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(run_lo) && !$past(ld_lo) && !irq_lo) |-> (cnt_lo == $past(cnt_lo) + 1'b1));

  p_once_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_lo && $past(run_q[7:6] == 2'd1) && !$past(wr_run)) |-> (run_q[7:6] == 2'd0));

  p_other_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_lo && !irq_hi && !$past(wr_run)) |-> (run_q[23:22] == $past(run_q[23:22])));

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(run_lo) && !$past(ld_lo)) |-> $stable(cnt_lo));

  p_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(run_lo) |-> !irq_lo);

  p_cmp_equal_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_evt |-> (cnt_lo == cmp_val));

endmodule

bind dual_timer dual_timer_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .reg_wr   (reg_wr),
  .reg_addr (reg_addr),
  .irq_lo   (irq_lo),
  .irq_hi   (irq_hi),
  .cmp_evt  (cmp_evt),
  .run_q    (run_q),
  .cnt_lo   (cnt[0]),
  .cmp_val  (cmp_q),
  .run_lo   (run[0])
);

// File: tb/sim_dual_timer.sv
`timescale 1ns/1ps
module sim_dual_timer;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_lo, irq_hi, cmp_evt;

  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;
  bit fin = 1'b0;

  typedef struct {
    int    kind;
    int    at;
    string req;
  } ev_t;
  ev_t sbq[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dual_timer u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_lo(irq_lo), .irq_hi(irq_hi), .cmp_evt(cmp_evt)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic push(int kind, int at, string req);
    ev_t e;
    e.kind = kind; e.at = at; e.req = req;
    sbq.push_back(e);
  endtask

  task automatic sb_pop(int kind);
    ev_t e;
    n_chk++;
    if (sbq.size() == 0) begin
      n_fail++;
      $display("FAIL %s unexpected pulse kind %0d at cycle %0d: actual pulse expected none",
               (kind == 2) ? "R9" : "R6", kind, cyc);
    end else begin
      e = sbq.pop_front();
      if (e.kind != kind || e.at != cyc) begin
        n_fail++;
        $display("FAIL %s pulse: actual kind %0d cycle %0d expected kind %0d cycle %0d",
                 e.req, kind, cyc, e.kind, e.at);
      end
    end
  endtask

  // monitor: compares produced pulses against the scoreboard
  always @(negedge clk) begin
    if (rst_n && !fin) begin
      if (irq_lo)  sb_pop(0);
      if (irq_hi)  sb_pop(1);
      if (cmp_evt) sb_pop(2);
    end
  end

  task automatic wr(logic [7:0] a, logic [31:0] d, output int land);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0;
    land = cyc;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_to(int t);
    while (cyc < t) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic drained(string req);
    n_chk++;
    if (sbq.size() != 0) begin
      n_fail++;
      $display("FAIL %s missing pulses: actual %0d pending expected 0 (next cycle %0d)",
               req, sbq.size(), sbq[0].at);
      sbq.delete();
    end
  endtask

  task automatic summary();
    fin = 1'b1;
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int e, x;
    logic [31:0] d;

    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1: reset state
    chk("R1", "irq_lo", {31'b0, irq_lo}, 32'd0);
    chk("R1", "irq_hi", {31'b0, irq_hi}, 32'd0);
    chk("R1", "cmp_evt", {31'b0, cmp_evt}, 32'd0);
    for (int a = 8'h10; a <= 8'h28; a += 4) begin
      rd(8'(a), d);
      chk("R1", $sformatf("reg %h", a), d, 32'd0);
    end

    // setup: compare parked where no phase steps onto it
    wr(8'h28, 32'hFFFF_FF00, x);
    wr(8'h24, 32'h0000_0007, x);
    wr(8'h18, 32'd4, x);
    wr(8'h1C, 32'd6, x);
    rd(8'h18, d); chk("R2", "low period readback", d, 32'd4);
    rd(8'h1C, d); chk("R2", "high period readback", d, 32'd6);
    rd(8'h24, d); chk("R2", "config readback", d, 32'd7);
    rd(8'h28, d); chk("R2", "compare readback", d, 32'hFFFF_FF00);
    rd(8'h30, d); chk("R2", "unmapped read", d, 32'd0);

    // Phase A: R3 R4 R8, both halves repeating on unequal periods
    wr(8'h20, (32'd2 << 6) | (32'd2 << 22), e);
    push(0, e + 5, "R4"); push(1, e + 7, "R8"); push(0, e + 10, "R4");
    push(1, e + 14, "R8"); push(0, e + 15, "R4"); push(0, e + 20, "R4");
    push(1, e + 21, "R8");
    wait_to(e + 22);
    wr(8'h20, 32'd0, x);
    repeat (4) @(posedge clk);
    rd(8'h10, d); chk("R3", "low count after stop", d, 32'd3);
    rd(8'h14, d); chk("R3", "high count after stop", d, 32'd2);
    drained("R4");

    // Phase B: R5 single-shot low, repeating high
    wr(8'h10, 32'd0, x);
    wr(8'h14, 32'd0, x);
    wr(8'h18, 32'd3, x);
    wr(8'h1C, 32'd100, x);
    wr(8'h20, (32'd1 << 6) | (32'd2 << 22), e);
    push(0, e + 4, "R5");
    wait_to(e + 10);
    rd(8'h20, d); chk("R5", "low field cleared, high kept", d, 32'd2 << 22);
    rd(8'h10, d); chk("R5", "low counter parked at zero", d, 32'd0);
    wr(8'h20, 32'd0, x);
    drained("R5");

    // Phase C: R6 held in reset, then wrong global mode
    wr(8'h24, 32'h0000_0006, x);
    wr(8'h10, 32'd0, x);
    wr(8'h18, 32'd2, x);
    wr(8'h20, 32'd2 << 6, x);
    repeat (10) @(posedge clk);
    rd(8'h10, d); chk("R6", "count held in reset", d, 32'd0);
    wr(8'h24, 32'h0000_0003, x);
    repeat (10) @(posedge clk);
    rd(8'h10, d); chk("R6", "count held in mode 0", d, 32'd0);
    wr(8'h20, 32'd0, x);
    wr(8'h24, 32'h0000_0007, x);
    repeat (5) @(posedge clk);
    rd(8'h10, d); chk("R6", "count held while stopped", d, 32'd0);
    drained("R6");

    // Phase D: R10 full-range wrap, R7 load while running
    wr(8'h18, 32'hFFFF_FFFF, x);
    wr(8'h10, 32'hFFFF_FFFD, x);
    wr(8'h20, 32'd2 << 6, e);
    push(0, e + 3, "R10");
    push(0, e + 12, "R7");
    wait_to(e + 5);
    wr(8'h10, 32'hFFFF_FFFA, x);
    chk("R7", "load landing cycle", x, e + 6);
    wait_to(e + 13);
    wr(8'h20, 32'd0, x);
    repeat (3) @(posedge clk);
    rd(8'h10, d); chk("R10", "count after wrap", d, 32'd2);
    drained("R10");

    // Phase E: R9 compare event on every pass
    wr(8'h28, 32'd2, x);
    wr(8'h18, 32'd4, x);
    wr(8'h10, 32'd0, x);
    wr(8'h20, 32'd2 << 6, e);
    push(2, e + 2, "R9"); push(0, e + 5, "R4"); push(2, e + 7, "R9");
    push(0, e + 10, "R4"); push(2, e + 12, "R9");
    wait_to(e + 13);
    wr(8'h20, 32'd0, x);
    wr(8'h10, 32'd2, x);
    repeat (6) @(posedge clk);
    rd(8'h10, d); chk("R9", "stopped on compare value", d, 32'd2);
    drained("R9");

    summary();
  end

endmodule